// File: doc/BRIEF.md
# Hi/Lo Register Integer Multiply Unit

This block is the multiply unit of a small load-store processor. It takes two register operands and a three-bit command. It forms the full double-width product in one combinational pass. The multiplicand is ANDed with each multiplier bit to make one partial product row per bit. The rows are then added by a fully unrolled, balanced adder tree instead of an iterative shift-and-add loop.

Multiply commands store the product in a pair of architectural registers. Hi holds the upper half and Lo the lower half. Two move commands place either register on the result port. A three-operand multiply returns the low half of the product directly on that port and leaves the register pair untouched. No command ever flags overflow. Software checks Hi to find out whether a product exceeded one word.

Top module: `mul_hilo_unit`

## Requirements
- R1: Command 3'b000 (signed multiply), presented with valid_i high, writes the exact two's-complement product of rs_i and rt_i into Hi (upper WIDTH bits) and Lo (lower WIDTH bits) at the next rising clock edge.
- R2: Command 3'b001 (unsigned multiply), presented with valid_i high, writes the exact unsigned product into Hi and Lo at the next rising clock edge.
- R3: Command 3'b010 (read Hi) drives the current Hi onto result_o in the same cycle and leaves Hi and Lo unchanged.
- R4: Command 3'b011 (read Lo) drives the current Lo onto result_o in the same cycle and leaves Hi and Lo unchanged.
- R5: Command 3'b100 (low-word multiply) drives the low WIDTH bits of the product onto result_o in the same cycle and does not modify Hi or Lo.
- R6: While valid_i is low, result_o is zero and Hi and Lo keep their values whatever command is presented.
- R7: A synchronous reset, rst high at a rising edge, clears Hi and Lo to zero.
- R8: The command codes 3'b101, 3'b110 and 3'b111 leave Hi and Lo unchanged and drive result_o to zero. Both multiply commands 3'b000 and 3'b001 also drive result_o to zero.
- R9: Products are exact at the operand extremes. These include the most negative value times itself (signed), all-ones times all-ones (unsigned), and the combinations of zero, one, all-ones and the sign bit alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Command strobe |
| op_i | input | 3 | Command code |
| rs_i | input | WIDTH | Multiplicand operand |
| rt_i | input | WIDTH | Multiplier operand |
| result_o | output | WIDTH | Move or low-word result |

## Verification
The bench builds two instances. The first uses WIDTH=4. At that width every operand pair can be swept, in both signed and unsigned form, so each sign combination and the wrap of the most negative value are covered completely. The second instance uses the default WIDTH=32. It receives the corner operands zero, one, all-ones, the sign bit alone and the largest positive value, plus a batch of pseudo-random pairs, so the full-size 32-row tree is exercised. Reference products come from 64-bit integer arithmetic in the bench.

// File: rtl/mul_pkg.sv
package mul_pkg;

    typedef enum logic [2:0] {
        OP_MUL_S   = 3'b000,
        OP_MUL_U   = 3'b001,
        OP_RD_HI   = 3'b010,
        OP_RD_LO   = 3'b011,
        OP_MUL_LOW = 3'b100
    } mul_op_e;

endpackage

// File: rtl/mul_pp_gen.sv
module mul_pp_gen #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]                  mcand_i,
    input  logic [WIDTH-1:0]                  mplier_i,
    input  logic                              signed_i,
    output logic [WIDTH-1:0][2*WIDTH-1:0]     rows_o
);
    localparam int PW = 2 * WIDTH;

    logic [PW-1:0] mcand_ext;

    // Sign- or zero-extend the multiplicand to the full product width.
    always_comb begin
        if (signed_i) begin
            mcand_ext = {{WIDTH{mcand_i[WIDTH-1]}}, mcand_i};
        end else begin
            mcand_ext = {{WIDTH{1'b0}}, mcand_i};
        end
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_row
        logic [PW-1:0] gated;
        assign gated = (mcand_ext & {PW{mplier_i[i]}}) << i;
        if (i == WIDTH - 1) begin : g_top
            // The multiplier sign bit carries negative weight when signed.
            always_comb begin
                if (signed_i) begin
                    rows_o[i] = ~gated + {{(PW-1){1'b0}}, 1'b1};
                end else begin
                    rows_o[i] = gated;
                end
            end
        end else begin : g_mid
            assign rows_o[i] = gated;
        end
    end

endmodule

// File: rtl/mul_adder_tree.sv
module mul_adder_tree #(
    parameter int ROWS  = 32,
    parameter int SUM_W = 64
) (
    input  logic [ROWS-1:0][SUM_W-1:0] rows_i,
    output logic [SUM_W-1:0]           sum_o
);
    localparam int LEVELS = (ROWS > 1) ? $clog2(ROWS) : 0;
    localparam int LEAVES = 1 << LEVELS;

    for (genvar lv = 0; lv <= LEVELS; lv++) begin : g_lvl
        localparam int CNT = LEAVES >> lv;
        logic [SUM_W-1:0] s [CNT];
        for (genvar j = 0; j < CNT; j++) begin : g_node
            if (lv == 0) begin : g_leaf
                if (j < ROWS) begin : g_used
                    assign s[j] = rows_i[j];
                end else begin : g_pad
                    assign s[j] = '0;
                end
            end else begin : g_add
                assign s[j] = g_lvl[lv-1].s[2*j] + g_lvl[lv-1].s[2*j+1];
            end
        end
    end

    assign sum_o = g_lvl[LEVELS].s[0];

endmodule

// File: rtl/mul_hilo_unit.sv
module mul_hilo_unit
    import mul_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_i,
    input  logic [2:0]       op_i,
    input  logic [WIDTH-1:0] rs_i,
    input  logic [WIDTH-1:0] rt_i,
    output logic [WIDTH-1:0] result_o
);
    localparam int PW = 2 * WIDTH;

    typedef struct packed {
        logic [WIDTH-1:0] hi;
        logic [WIDTH-1:0] lo;
    } hilo_t;

    hilo_t                     st_d, st_q;
    logic                      sgn_sel;
    logic [WIDTH-1:0][PW-1:0]  pp_rows;
    logic [PW-1:0]             prod;
    logic [WIDTH-1:0]          hi_q, lo_q;
    logic [WIDTH-1:0]          result_d;
    mul_op_e                   op;

    assign op      = mul_op_e'(op_i);
    assign sgn_sel = (op_i != OP_MUL_U);

    mul_pp_gen #(.WIDTH(WIDTH)) u_pp (
        .mcand_i  (rs_i),
        .mplier_i (rt_i),
        .signed_i (sgn_sel),
        .rows_o   (pp_rows)
    );

    mul_adder_tree #(.ROWS(WIDTH), .SUM_W(PW)) u_tree (
        .rows_i (pp_rows),
        .sum_o  (prod)
    );

    always_comb begin
        st_d     = st_q;
        result_d = '0;
        if (valid_i) begin
            case (op)
                OP_MUL_S, OP_MUL_U: begin
                    st_d.hi = prod[PW-1:WIDTH];
                    st_d.lo = prod[WIDTH-1:0];
                end
                OP_RD_HI:   result_d = st_q.hi;
                OP_RD_LO:   result_d = st_q.lo;
                OP_MUL_LOW: result_d = prod[WIDTH-1:0];
                default:    result_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hi_q     = st_q.hi;
    assign lo_q     = st_q.lo;
    assign result_o = result_d;

endmodule

// File: rtl/mul_hilo_unit_chk.sv
module mul_hilo_unit_chk
    import mul_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               valid_i,
    input logic [2:0]         op_i,
    input logic [WIDTH-1:0]   result_o,
    input logic [WIDTH-1:0]   hi_q,
    input logic [WIDTH-1:0]   lo_q,
    input logic [2*WIDTH-1:0] prod
);
    assert_mul_s_R1: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == OP_MUL_S) |=> ({hi_q, lo_q} == $past(prod)));

    assert_mul_u_R2: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == OP_MUL_U) |=> ({hi_q, lo_q} == $past(prod)));

    assert_rd_hi_R3: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == OP_RD_HI) |-> (result_o == hi_q));

    assert_rd_lo_R4: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == OP_RD_LO) |-> (result_o == lo_q));

    assert_low_word_R5: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == OP_MUL_LOW) |-> (result_o == prod[WIDTH-1:0]));

    assert_keep_R5: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i[2]) |=> ($stable(hi_q) && $stable(lo_q)));

    assert_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !valid_i |-> (result_o == '0));

    assert_idle_keep_R6: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> ($stable(hi_q) && $stable(lo_q)));

    assert_unused_R8: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i > 3'b100) |-> (result_o == '0));

endmodule

bind mul_hilo_unit mul_hilo_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .valid_i  (valid_i),
    .op_i     (op_i),
    .result_o (result_o),
    .hi_q     (hi_q),
    .lo_q     (lo_q),
    .prod     (prod)
);

// File: tb/mul_hilo_unit_tb.sv
module mul_hilo_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid = 1'b0;
    logic [2:0]  op = 3'b000;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic [3:0]  res_n;
    logic [31:0] res_w;
    int          n_checks = 0;
    int          n_fail = 0;

    always #2 clk = ~clk;

    mul_hilo_unit #(.WIDTH(4)) u_dut (
        .clk (clk), .rst (rst), .valid_i (valid), .op_i (op),
        .rs_i (a[3:0]), .rt_i (b[3:0]), .result_o (res_n)
    );

    mul_hilo_unit #(.WIDTH(32)) u_dut_wide (
        .clk (clk), .rst (rst), .valid_i (valid), .op_i (op),
        .rs_i (a), .rt_i (b), .result_o (res_w)
    );

    function automatic logic [31:0] wmask(int w);
        return (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    endfunction

    function automatic logic [63:0] ref_prod(int w, bit sgn, logic [31:0] x, logic [31:0] y);
        logic [31:0] m = wmask(w);
        longint sx = longint'({32'b0, x & m});
        longint sy = longint'({32'b0, y & m});
        if (sgn) begin
            if (x[w-1]) sx = sx - (64'sd1 <<< w);
            if (y[w-1]) sy = sy - (64'sd1 <<< w);
            return 64'(sx * sy);
        end
        return 64'({32'b0, x & m}) * 64'({32'b0, y & m});
    endfunction

    function automatic logic [31:0] rd(int w);
        return (w == 32) ? res_w : {28'b0, res_n};
    endfunction

    task automatic step(logic v, logic [2:0] o, logic [31:0] x, logic [31:0] y);
        @(negedge clk);
        valid = v; op = o; a = x; b = y;
        #1;
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Multiply, then low-word multiply (R5), then read Hi (R3) and Lo (R4).
    task automatic run_mult(int w, bit sgn, logic [31:0] x, logic [31:0] y, string req);
        logic [63:0] p = ref_prod(w, sgn, x, y);
        logic [31:0] m = wmask(w);
        logic [31:0] ehi = 32'(p >> w) & m;
        logic [31:0] elo = p[31:0] & m;
        step(1'b1, sgn ? 3'b000 : 3'b001, x, y);
        check({req, "/R8 mult result"}, rd(w), 32'h0);
        step(1'b1, 3'b100, x, y);
        check({req, "/R5 low word"}, rd(w), elo);
        step(1'b1, 3'b010, 32'h0, 32'h0);
        check({req, "/R3 hi"}, rd(w), ehi);
        step(1'b1, 3'b011, 32'h0, 32'h0);
        check({req, "/R4 lo"}, rd(w), elo);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] corners [5] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF};
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R7: reset state
        step(1'b1, 3'b010, 32'h0, 32'h0);
        check("R7 hi after reset", rd(32), 32'h0);
        step(1'b1, 3'b011, 32'h0, 32'h0);
        check("R7 lo after reset", rd(32), 32'h0);

        // R1, R2: exhaustive sweep at WIDTH=4
        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                run_mult(4, 1'b1, 32'(x), 32'(y), "R1");
                run_mult(4, 1'b0, 32'(x), 32'(y), "R2");
            end
        end

        // R9: corners at WIDTH=32
        for (int i = 0; i < 5; i++) begin
            for (int j = 0; j < 5; j++) begin
                run_mult(32, 1'b1, corners[i], corners[j], "R9 signed");
                run_mult(32, 1'b0, corners[i], corners[j], "R9 unsigned");
            end
        end

        // R1, R2: pseudo-random at WIDTH=32
        for (int k = 0; k < 150; k++) begin
            logic [31:0] rx = $urandom;
            logic [31:0] ry = $urandom;
            run_mult(32, k[0], rx, ry, k[0] ? "R1 rand" : "R2 rand");
        end

        // R6: idle strobe leaves Hi/Lo and gives zero result
        run_mult(32, 1'b0, 32'h1234_5678, 32'h9ABC_DEF0, "R2");
        step(1'b0, 3'b001, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        check("R6 idle result", rd(32), 32'h0);
        step(1'b0, 3'b010, 32'h0, 32'h0);
        check("R6 idle read", rd(32), 32'h0);
        step(1'b1, 3'b010, 32'h0, 32'h0);
        check("R6 hi kept", rd(32), 32'(ref_prod(32, 1'b0, 32'h1234_5678, 32'h9ABC_DEF0) >> 32));

        // R8: unused codes
        for (int c = 5; c < 8; c++) begin
            step(1'b1, 3'(c), 32'hFFFF_FFFF, 32'h8000_0000);
            check("R8 unused result", rd(32), 32'h0);
        end
        step(1'b1, 3'b011, 32'h0, 32'h0);
        check("R8 lo kept", rd(32), ref_prod(32, 1'b0, 32'h1234_5678, 32'h9ABC_DEF0) & 64'hFFFF_FFFF);

        // R3/R4: repeated reads do not disturb
        step(1'b1, 3'b010, 32'h0, 32'h0);
        step(1'b1, 3'b011, 32'h0, 32'h0);
        step(1'b1, 3'b010, 32'h0, 32'h0);
        check("R3 hi after reads", rd(32), 32'(ref_prod(32, 1'b0, 32'h1234_5678, 32'h9ABC_DEF0) >> 32));

        // R7: reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        step(1'b1, 3'b010, 32'h0, 32'h0);
        check("R7 hi cleared", rd(32), 32'h0);
        step(1'b1, 3'b011, 32'h0, 32'h0);
        check("R7 lo cleared", rd(32), 32'h0);
        check("R7 narrow lo cleared", rd(4), 32'h0);

        finish_run();
    end

endmodule